// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional jump, call or return is taken. It takes a 4-bit condition code and seven status flags and produces one bit that says whether the condition holds. The flags are negative (n), overflow (v), zero (z), carry (c), extension (e), unnormalized (u) and test bit (tb). Producing the flags and computing the branch target are done elsewhere.

Most codes come in pairs, and the second code of a pair is the inverse of the first. The first three pairs are the usual signed and equality tests. Further pairs test carry, the extension flag, a "minus" condition built from the zero, unnormalized and extension flags, and the test-bit flag. The last two codes test overflow alone and give an unconditional true. The decision logic is combinational. A parameter `OUT_REG` can add one output register, so that the result can be placed in a pipeline stage.

Top module: `cond_eval`

## Requirements
- R1: Code 0 (ge) is true when n XOR v is 0. Code 1 (lt) is true when n XOR v is 1.
- R2: Code 2 (gt) is true when z OR (n XOR v) is 0. Code 3 (le) is true when that term is 1.
- R3: Code 4 (nz) is true when z is 0. Code 5 (z) is true when z is 1.
- R4: Code 6 (nc) is true when c is 0. Code 7 (c) is true when c is 1.
- R5: Code 8 (ne) is true when e is 0. Code 9 (e) is true when e is 1.
- R6: Code 10 (nm) is true when z OR (NOT u AND NOT e) is 0. Code 11 (m) is true when that term is 1.
- R7: Code 12 (nt) is true when tb is 0. Code 13 (t) is true when tb is 1.
- R8: Code 14 is true exactly when v is 1, whatever the other flags are.
- R9: Code 15 (always) is true for every flag combination.
- R10: With `OUT_REG`=1 (the default), `cond_true` shows the decision for the code and flags sampled at the previous rising clock edge. It is 0 while `rst_n` is low, and the reset is asynchronous and active low. With `OUT_REG`=0 the output is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_code | input | 4 | Condition code, 0 to 15 |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_e | input | 1 | Extension flag |
| flag_u | input | 1 | Unnormalized flag |
| flag_tb | input | 1 | Test-bit flag |
| cond_true | output | 1 | Condition holds |

## Verification
The bench applies all 128 flag combinations under every one of the 16 codes, and then a seeded random stream. Each result is compared against a reference function written from the requirements.

The bench targets specific corner cases:
- Code 14 would be wrong in a design that treats the last pair like the others; it would then give NOT v.
- A nm/m design that drops the u or e term gives the wrong answer when z is 0 and only one of u and e is set.
- gt would be wrong in a design that omits z; it would then report true on equality.
- The reset case catches an output that shows code 15 during reset, or an output that appears a cycle early.

// File: rtl/cond_pkg.sv
package cond_pkg;
    localparam int CODE_W  = 4;
    localparam int PAIRS   = 1 << (CODE_W - 1);

    typedef enum logic [CODE_W-1:0] {
        CC_GE = 4'd0,  CC_LT = 4'd1,  CC_GT = 4'd2,  CC_LE = 4'd3,
        CC_NZ = 4'd4,  CC_Z  = 4'd5,  CC_NC = 4'd6,  CC_C  = 4'd7,
        CC_NE = 4'd8,  CC_E  = 4'd9,  CC_NM = 4'd10, CC_M  = 4'd11,
        CC_NT = 4'd12, CC_T  = 4'd13, CC_V  = 4'd14, CC_AL = 4'd15
    } cond_code_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
        logic e;
        logic u;
        logic tb;
    } status_t;

    typedef struct packed {
        logic hit;
    } out_state_t;
endpackage

// File: rtl/cond_terms.sv
module cond_terms
    import cond_pkg::*;
(
    input  status_t           flags,
    output logic [PAIRS-1:0]  pair_term
);
    logic sign_mismatch;
    logic nonpos;
    logic minus_term;

    always_comb begin
        sign_mismatch = flags.n ^ flags.v;
        nonpos        = flags.z | sign_mismatch;
        minus_term    = flags.z | (~flags.u & ~flags.e);
        pair_term     = '0;
        pair_term[0]  = sign_mismatch;
        pair_term[1]  = nonpos;
        pair_term[2]  = flags.z;
        pair_term[3]  = flags.c;
        pair_term[4]  = flags.e;
        pair_term[5]  = minus_term;
        pair_term[6]  = flags.tb;
        pair_term[PAIRS-1] = flags.v;
    end
endmodule

// File: rtl/cond_mux.sv
module cond_mux
    import cond_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [PAIRS-1:0]  pair_term,
    output logic              hit
);
    logic [CODE_W-2:0] pair_sel;
    logic              odd;

    always_comb begin
        pair_sel = code[CODE_W-1:1];
        odd      = code[0];
        if (pair_sel == CODE_W'(PAIRS - 1) >> 0 && pair_sel == (CODE_W-1)'(PAIRS - 1))
            hit = odd | pair_term[PAIRS-1];
        else
            hit = pair_term[pair_sel] ^ ~odd;
    end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cond_code,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_e,
    input  logic              flag_u,
    input  logic              flag_tb,
    output logic              cond_true
);
    status_t          flags;
    logic [PAIRS-1:0] pair_term;
    logic             hit_comb;
    out_state_t       state_d;

    always_comb begin
        flags.n  = flag_n;
        flags.v  = flag_v;
        flags.z  = flag_z;
        flags.c  = flag_c;
        flags.e  = flag_e;
        flags.u  = flag_u;
        flags.tb = flag_tb;
    end

    cond_terms u_terms (
        .flags     (flags),
        .pair_term (pair_term)
    );

    cond_mux u_mux (
        .code      (cond_code),
        .pair_term (pair_term),
        .hit       (hit_comb)
    );

    always_comb begin
        state_d.hit = hit_comb;
    end

    generate
        if (OUT_REG) begin : g_reg
            out_state_t state_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) state_q <= '0;
                else        state_q <= state_d;
            end
            assign cond_true = state_q.hit;

            // R1: ge follows n XOR v
            assert_ge_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (cond_code == CC_GE) |=> (cond_true == ~($past(flag_n) ^ $past(flag_v))));
            // R2: gt is false on equality
            assert_gt_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (cond_code == CC_GT && flag_z) |=> !cond_true);
            // R3: z follows the zero flag
            assert_z_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (cond_code == CC_Z) |=> (cond_true == $past(flag_z)));
            // R6: m holds when u and e are both clear
            assert_m_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (cond_code == CC_M && !flag_u && !flag_e) |=> cond_true);
            // R8: code 14 follows overflow only
            assert_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (cond_code == CC_V) |=> (cond_true == $past(flag_v)));
            // R9: always is true
            assert_always_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (cond_code == CC_AL) |=> cond_true);
        end else begin : g_comb
            assign cond_true = state_d.hit;
        end
    endgenerate
endmodule

// File: tb/cond_eval_test.sv
module cond_eval_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cond_code = 4'd0;
    logic [6:0] fl = 7'd0;   // {n,v,z,c,e,u,tb}
    logic       cond_true;
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done     = 1'b0;

    always #5 clk = ~clk;

    cond_eval uut (
        .clk(clk), .rst_n(rst_n), .cond_code(cond_code),
        .flag_n(fl[6]), .flag_v(fl[5]), .flag_z(fl[4]), .flag_c(fl[3]),
        .flag_e(fl[2]), .flag_u(fl[1]), .flag_tb(fl[0]),
        .cond_true(cond_true)
    );

    function automatic bit ref_cond(input logic [3:0] cc, input logic [6:0] f);
        bit n, v, z, c, e, u, tb;
        {n, v, z, c, e, u, tb} = f;
        case (cc)
            4'd0:  return (n ^ v) == 1'b0;          // R1
            4'd1:  return (n ^ v) == 1'b1;          // R1
            4'd2:  return (z | (n ^ v)) == 1'b0;    // R2
            4'd3:  return (z | (n ^ v)) == 1'b1;    // R2
            4'd4:  return !z;                       // R3
            4'd5:  return z;                        // R3
            4'd6:  return !c;                       // R4
            4'd7:  return c;                        // R4
            4'd8:  return !e;                       // R5
            4'd9:  return e;                        // R5
            4'd10: return (z | (!u & !e)) == 1'b0;  // R6
            4'd11: return (z | (!u & !e)) == 1'b1;  // R6
            4'd12: return !tb;                      // R7
            4'd13: return tb;                       // R7
            4'd14: return v;                        // R8
            default: return 1'b1;                   // R9
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] cc);
        case (cc[3:1])
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return cc[0] ? "R9" : "R8";
        endcase
    endfunction

    task automatic check(input string req, input bit exp);
        n_checks++;
        if (cond_true !== exp) begin
            n_fail++;
            $display("FAIL %s code=%0d flags=%b actual=%b expected=%b",
                     req, cond_code, fl, cond_true, exp);
        end
    endtask

    // drive at negedge, result registered at next posedge, checked at following negedge (R10)
    task automatic apply(input logic [3:0] cc, input logic [6:0] f);
        bit exp;
        @(negedge clk);
        cond_code = cc;
        fl        = f;
        exp       = ref_cond(cc, f);
        @(negedge clk);
        check(req_of(cc), exp);
    endtask

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        // R10: reset holds output low even with code 15
        cond_code = 4'd15;
        repeat (3) @(negedge clk);
        check("R10", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", 1'b1);
        // R10: latency of one edge - new input not visible before posedge
        @(negedge clk);
        cond_code = 4'd5; fl = 7'b0000000;
        #1 check("R10", 1'b1);
        @(negedge clk);
        check("R10", 1'b0);
        // directed corners
        apply(4'd2, 7'b0010000);   // R2 gt false on z
        apply(4'd10, 7'b0000100);  // R6 nm: e only -> true
        apply(4'd10, 7'b0000010);  // R6 nm: u only -> true
        apply(4'd11, 7'b0000000);  // R6 m: neither -> true
        apply(4'd14, 7'b0100000);  // R8
        apply(4'd14, 7'b1011111);  // R8 v clear, others set
        // exhaustive sweep
        for (int cc = 0; cc < 16; cc++)
            for (int f = 0; f < 128; f++)
                apply(4'(cc), 7'(f));
        // random
        for (int i = 0; i < 500; i++)
            apply(4'($urandom()), 7'($urandom()));
        done = 1'b1;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
    end

    initial begin
        wait (done);
        #20;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && $time > 64'd199000) begin
            done <= 1'b1;
        end
    end
endmodule